// File: doc/BRIEF.md
# Facility Availability Checker

This block decides, in a single cycle, whether a request to use an optional processor facility may proceed. Each request carries a facility bit index, an interrupt-cause code and a selector naming the control source that governs the facility. The source can be a supervisor-level control register, the current machine-state word, or a performance-monitor control register. A request can also ask for an additional hypervisor-level check against a hypervisor control register. The block compares the request with the privilege qualifiers (hypervisor mode present, hypervisor state active, user state active) and with the register contents. It then either grants the request or raises exactly one of two facility-unavailable exceptions, one of hypervisor class and one of supervisor class.

The block owns the hypervisor, supervisor and performance-monitor control registers, and each has a full-word write port. The top byte of each of the two facility control registers is an interrupt-cause field. The block updates that field itself whenever it raises an exception, so that the trap handler can read why the access was refused. Exception vectoring and instruction decode are left to the surrounding pipeline. The pipeline sees the exception as a one-cycle output that is valid together with the request strobe.

Top module: `fac_gate`

## Requirements
- R1: After reset the hypervisor, supervisor and performance-monitor control registers read zero, and req_grant, exc_hv, exc_sup and exc_cause are all zero.
- R2: A write enable loads the full 64-bit write data into its register at the next clock edge, and the value is visible on the matching read port from then on.
- R3: With req_kind = 1 (supervisor register check), the request faults on the supervisor path when bit req_sbit of the supervisor register is 0 and is granted when that bit is 1. The result appears in the same cycle as req_valid, and grant, exc_hv and exc_sup are never active together.
- R4: With req_hchk = 1, a hypervisor fault is raised only when hv_exists = 1, hv_mode = 0 and bit req_hbit of the hypervisor register is 0. Otherwise the hypervisor check passes.
- R5: On a hypervisor fault, exc_hv is high and exc_cause carries the full 16-bit req_cause. At the next edge bits 63:56 of the hypervisor register become zero and its other bits are kept.
- R6: On a supervisor-path fault, exc_sup is high and exc_cause is zero. At the next edge bits 63:56 of the supervisor register take the low 8 bits of req_cause, and its other bits are kept.
- R7: With req_kind = 2 (machine-state check), the request faults on the supervisor path when bit req_sbit of mstate is 0, whatever the value of user_mode.
- R8: With req_kind = 3 (performance-monitor check), the request faults on the supervisor path only when user_mode = 1 and bit req_sbit of the performance-monitor register is 0.
- R9: When the hypervisor check faults, the supervisor-path check is suppressed: exc_sup stays low and the supervisor register is left unchanged.
- R10: While req_valid is 0, every result output is 0 and no register changes without a write. A valid request with req_kind = 0 and req_hchk = 0 is always granted.
- R11: When a fault updates a cause field in the same cycle as a write to that register, the fault's value goes into bits 63:56 and the write data fills the remaining bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hctl_we | input | 1 | Hypervisor control register write enable |
| hctl_wdata | input | 64 | Hypervisor control register write data |
| sctl_we | input | 1 | Supervisor control register write enable |
| sctl_wdata | input | 64 | Supervisor control register write data |
| pmon_we | input | 1 | Performance-monitor control register write enable |
| pmon_wdata | input | 64 | Performance-monitor control register write data |
| mstate | input | 64 | Current machine-state word |
| hv_exists | input | 1 | Hypervisor mode is implemented |
| hv_mode | input | 1 | Processor is in hypervisor state |
| user_mode | input | 1 | Processor is in problem (user) state |
| req_valid | input | 1 | Request strobe |
| req_hchk | input | 1 | Also apply the hypervisor check |
| req_hbit | input | 6 | Bit index into the hypervisor register |
| req_kind | input | 2 | 0 none, 1 supervisor register, 2 machine state, 3 performance monitor |
| req_sbit | input | 6 | Bit index for the req_kind source |
| req_cause | input | 16 | Interrupt-cause code |
| req_grant | output | 1 | Request granted |
| exc_hv | output | 1 | Hypervisor-class facility exception |
| exc_sup | output | 1 | Supervisor-class facility exception |
| exc_cause | output | 16 | Cause passed with the hypervisor exception, zero otherwise |
| hctl_q | output | 64 | Hypervisor control register contents |
| sctl_q | output | 64 | Supervisor control register contents |
| pmon_q | output | 64 | Performance-monitor control register contents |

## Verification
Each source selector is tried with its governing bit both set and clear, so that a granted request and a faulted one are distinguished for the same register. The privilege qualifiers are then toggled one at a time: user_mode on machine-state and monitor requests, and hv_mode and hv_exists on hypervisor requests. This shows which checks depend on privilege and which do not. A request that fails both checks at once tells whether the hypervisor check wins, because the supervisor cause field must stay untouched. A fault that coincides with a register write shows how the two updates merge.

// File: rtl/fac_gate.sv
module fac_gate #(
  parameter int XLEN       = 64,
  parameter int IDX_W      = 6,
  parameter int CAUSE_W    = 8,
  parameter int CAUSE_IN_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hctl_we,
  input  logic [XLEN-1:0]       hctl_wdata,
  input  logic                  sctl_we,
  input  logic [XLEN-1:0]       sctl_wdata,
  input  logic                  pmon_we,
  input  logic [XLEN-1:0]       pmon_wdata,
  input  logic [XLEN-1:0]       mstate,
  input  logic                  hv_exists,
  input  logic                  hv_mode,
  input  logic                  user_mode,
  input  logic                  req_valid,
  input  logic                  req_hchk,
  input  logic [IDX_W-1:0]      req_hbit,
  input  logic [1:0]            req_kind,
  input  logic [IDX_W-1:0]      req_sbit,
  input  logic [CAUSE_IN_W-1:0] req_cause,
  output logic                  req_grant,
  output logic                  exc_hv,
  output logic                  exc_sup,
  output logic [CAUSE_IN_W-1:0] exc_cause,
  output logic [XLEN-1:0]       hctl_q,
  output logic [XLEN-1:0]       sctl_q,
  output logic [XLEN-1:0]       pmon_q
);
  localparam int FLD_HI = XLEN - 1;

  logic h_fault, s_fail, s_fault;

  assign h_fault = req_valid && req_hchk && hv_exists && !hv_mode && !hctl_q[req_hbit];

  always_comb begin
    case (req_kind)
      2'd1:    s_fail = !sctl_q[req_sbit];
      2'd2:    s_fail = !mstate[req_sbit];
      2'd3:    s_fail = user_mode && !pmon_q[req_sbit];
      default: s_fail = 1'b0;
    endcase
  end

  assign s_fault   = req_valid && !h_fault && s_fail;
  assign exc_hv    = h_fault;
  assign exc_sup   = s_fault;
  assign req_grant = req_valid && !h_fault && !s_fault;
  assign exc_cause = h_fault ? req_cause : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hctl_q <= '0;
      sctl_q <= '0;
      pmon_q <= '0;
    end else begin
      if (hctl_we) hctl_q <= hctl_wdata;
      if (h_fault) hctl_q[FLD_HI -: CAUSE_W] <= '0;
      if (sctl_we) sctl_q <= sctl_wdata;
      if (s_fault) sctl_q[FLD_HI -: CAUSE_W] <= req_cause[CAUSE_W-1:0];
      if (pmon_we) pmon_q <= pmon_wdata;
    end
  end
endmodule

// File: rtl/fac_gate_chk.sv
module fac_gate_chk #(
  parameter int XLEN       = 64,
  parameter int CAUSE_W    = 8,
  parameter int CAUSE_IN_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sctl_we,
  input logic                  hv_mode,
  input logic                  user_mode,
  input logic                  req_valid,
  input logic [1:0]            req_kind,
  input logic [CAUSE_IN_W-1:0] req_cause,
  input logic                  req_grant,
  input logic                  exc_hv,
  input logic                  exc_sup,
  input logic [XLEN-1:0]       hctl_q,
  input logic [XLEN-1:0]       sctl_q
);
  assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_grant, exc_hv, exc_sup}));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(req_grant || exc_hv || exc_sup));

  assert_hv_state_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hv_mode |-> !exc_hv);

  assert_hv_field_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_hv |=> hctl_q[XLEN-1 -: CAUSE_W] == '0);

  assert_sup_field_loaded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_sup |=> sctl_q[XLEN-1 -: CAUSE_W] == $past(req_cause[CAUSE_W-1:0]));

  assert_monitor_user_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd3 && !user_mode) |-> !exc_sup);

  assert_hv_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_hv && !sctl_we) |=> $stable(sctl_q));
endmodule

bind fac_gate fac_gate_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .CAUSE_IN_W(CAUSE_IN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sctl_we(sctl_we), .hv_mode(hv_mode), .user_mode(user_mode),
  .req_valid(req_valid), .req_kind(req_kind), .req_cause(req_cause),
  .req_grant(req_grant), .exc_hv(exc_hv), .exc_sup(exc_sup),
  .hctl_q(hctl_q), .sctl_q(sctl_q)
);

// File: tb/fac_gate_bench.sv
`timescale 1ns/1ps
module fac_gate_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic hctl_we = 0, sctl_we = 0, pmon_we = 0;
  logic [63:0] hctl_wdata = '0, sctl_wdata = '0, pmon_wdata = '0, mstate = '0;
  logic hv_exists = 0, hv_mode = 0, user_mode = 0;
  logic req_valid = 0, req_hchk = 0;
  logic [5:0] req_hbit = '0, req_sbit = '0;
  logic [1:0] req_kind = '0;
  logic [15:0] req_cause = '0;
  logic req_grant, exc_hv, exc_sup;
  logic [15:0] exc_cause;
  logic [63:0] hctl_q, sctl_q, pmon_q;

  fac_gate u_fac_gate (.*);

  int errors = 0, checks = 0;
  logic [63:0] m_h = '0, m_s = '0, m_p = '0;
  logic [18:0] exp_q[$];
  string tag_q[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regs(input string tag);
    #1;
    chk({tag, " hctl"}, hctl_q, m_h);
    chk({tag, " sctl"}, sctl_q, m_s);
    chk({tag, " pmon"}, pmon_q, m_p);
  endtask

  task automatic wr(input int sel, input logic [63:0] d);
    @(negedge clk);
    hctl_we = (sel == 0); sctl_we = (sel == 1); pmon_we = (sel == 2);
    hctl_wdata = d; sctl_wdata = d; pmon_wdata = d;
    if (sel == 0) m_h = d; else if (sel == 1) m_s = d; else m_p = d;
    @(negedge clk);
    hctl_we = 0; sctl_we = 0; pmon_we = 0;
  endtask

  task automatic rq(input string tag, input logic hc, input logic [5:0] hb, input logic [1:0] k,
                    input logic [5:0] sb, input logic [15:0] c,
                    input logic eg, input logic eh, input logic es);
    @(negedge clk);
    req_valid = 1; req_hchk = hc; req_hbit = hb; req_kind = k; req_sbit = sb; req_cause = c;
    exp_q.push_back({eg, eh, es, eh ? c : 16'h0});
    tag_q.push_back(tag);
    if (eh) m_h[63:56] = 8'h00;
    if (es) m_s[63:56] = c[7:0];
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk); #1;
      if (req_valid) begin
        logic [18:0] e;
        string t;
        if (exp_q.size() == 0) begin
          errors++; checks++;
          $display("FAIL R3 unexpected request actual=1 expected=0");
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, {45'b0, req_grant, exc_hv, exc_sup, exc_cause}, {45'b0, e});
        end
      end
    end
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 outputs", {60'b0, req_grant, exc_hv, exc_sup, |exc_cause}, 64'h0);
    regs("R1");

    wr(1, 64'h00F0_0000_0000_0005);
    wr(0, 64'hAB00_0000_0000_0010);
    wr(2, 64'h0000_0000_0000_0100);
    regs("R2");

    rq("R3 sup bit set", 0, 0, 2'd1, 6'd0, 16'h1234, 1, 0, 0);
    rq("R3 sup bit clear", 0, 0, 2'd1, 6'd1, 16'h1234, 0, 0, 1);
    regs("R6 cause masked");

    mstate = 64'h8; user_mode = 1;
    rq("R7 mstate set", 0, 0, 2'd2, 6'd3, 16'h00C7, 1, 0, 0);
    user_mode = 0;
    rq("R7 mstate clear", 0, 0, 2'd2, 6'd4, 16'h00C7, 0, 0, 1);
    regs("R7");

    user_mode = 0;
    rq("R8 kernel passes", 0, 0, 2'd3, 6'd5, 16'h005A, 1, 0, 0);
    user_mode = 1;
    rq("R8 user bit set", 0, 0, 2'd3, 6'd8, 16'h005A, 1, 0, 0);
    rq("R8 user bit clear", 0, 0, 2'd3, 6'd5, 16'h005A, 0, 0, 1);
    regs("R8");
    user_mode = 0;

    hv_exists = 1; hv_mode = 0;
    rq("R4 hv bit set", 1, 6'd4, 2'd0, 0, 16'hBEEF, 1, 0, 0);
    rq("R5 hv fault", 1, 6'd5, 2'd0, 0, 16'hBEEF, 0, 1, 0);
    regs("R5");
    hv_mode = 1;
    rq("R4 in hv state", 1, 6'd5, 2'd0, 0, 16'hBEEF, 1, 0, 0);
    hv_mode = 0; hv_exists = 0;
    rq("R4 no hv mode", 1, 6'd5, 2'd0, 0, 16'hBEEF, 1, 0, 0);
    hv_exists = 1;

    rq("R9 hv wins", 1, 6'd5, 2'd1, 6'd1, 16'h0077, 0, 1, 0);
    regs("R9");

    rq("R10 no checks", 0, 0, 2'd0, 0, 16'h0001, 1, 0, 0);
    @(negedge clk);
    req_valid = 0; req_hchk = 1; req_hbit = 6'd5; req_kind = 2'd1; req_sbit = 6'd1;
    #1;
    chk("R10 idle outputs", {60'b0, req_grant, exc_hv, exc_sup, |exc_cause}, 64'h0);
    @(negedge clk);
    regs("R10");

    @(negedge clk);
    sctl_we = 1; sctl_wdata = 64'h1111_1111_1111_1111;
    req_valid = 1; req_hchk = 0; req_kind = 2'd1; req_sbit = 6'd1; req_cause = 16'h0099;
    exp_q.push_back({1'b0, 1'b0, 1'b1, 16'h0});
    tag_q.push_back("R11 fault with write");
    m_s = 64'h9911_1111_1111_1111;
    @(negedge clk);
    sctl_we = 0; req_valid = 0;
    regs("R11");

    @(negedge clk); #1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule